// File: doc/BRIEF.md
# Snapshot-Read 64-bit Match Timer

This block is a free-running system timer for a processor subsystem. A 64-bit up-counter advances at a rate set by a programmable prescaler, and it wraps modulo 2^64. Six 32-bit compare channels watch the low half of the counter. Each channel records a hit in a sticky status bit. A per-channel enable mask combines the hits into one interrupt line. Software clears a hit by writing a one to its status bit.

A single 32-bit access cannot read a 64-bit count atomically. Software therefore writes a capture command, and the block copies the whole counter into a pair of read-back registers in that clock. Both halves then come from the same instant. Software can also overwrite either counter half directly. It does this to zero the count at start-up or to restore a saved value. The last compare channel can also act as a watchdog: when it is armed and it hits, a reset request is raised and held until the block is reset.

Register word offsets in bytes: count low 0x00, count high 0x04, compare channel n at 0x08+4n (n = 0..5), status 0x20, interrupt enable 0x24, watchdog arm 0x28, prescale 0x2C, capture command 0x30, captured low 0x34, captured high 0x38. Writes with address bits [1:0] not zero are ignored.

Top module: `snap_match_timer`

## Requirements
- R1: After reset, the count halves, the captured halves, status, interrupt enable, watchdog arm and prescale all read zero, and `irq_o` and `wdt_rst_req_o` are low.
- R2: With prescale value P (bits [15:0] of 0x2C), the counter advances by exactly one every 2*(P+1) clocks.
- R3: A carry out of the low half increments the high half on the same advance, and the 64-bit count wraps from all ones to zero.
- R4: A write to 0x00 or 0x04 loads that half of the count from the write data. An advance that falls in the same clock is dropped, so the written value is what the next clock sees.
- R5: A write to 0x30 with bit 0 set copies the 64-bit count, as it stands before that clock's advance, into 0x34 (low) and 0x38 (high). The copy holds until the next such write. A write to 0x30 with bit 0 clear leaves it unchanged, and 0x30 reads as zero.
- R6: Status bit n sets on the advance at which the low count half becomes equal to compare channel n. Other bits are unaffected.
- R7: Writing a one to status bit n clears it. Zero bits in the write leave their flags unchanged.
- R8: `irq_o` is high exactly when some status bit n and enable bit n (0x24, bit n) are both set. Status bits set whether or not they are enabled.
- R9: When bit 0 of 0x28 is set and channel 5 hits, `wdt_rst_req_o` rises and stays high until reset. A channel 5 hit while bit 0 is clear does not raise it.
- R10: The compare, interrupt enable, watchdog arm and prescale registers read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined enabled compare interrupt |
| wdt_rst_req_o | output | 1 | Sticky watchdog reset request |

## Verification
The bench sweeps the prescale value and measures the advance over a window of whole periods between two captures. A prescaler off by one clock would drift by several counts. Counter writes are repeated at both phases of the fastest tick, so a design that let an advance win over a write returns the written value plus one. Carry and full 64-bit wrap are forced by presetting near all ones; a missing carry leaves the high half stale. Each compare channel hits alone, and the capture taken right after the flag appears must equal the compare value, which exposes a hit flagged one count early or late. The watchdog is tried disarmed, armed, and then after being disarmed again.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register word indexes (byte offset / 4)
  localparam logic [5:0] IDX_CNT_LO  = 6'd0;
  localparam logic [5:0] IDX_CNT_HI  = 6'd1;
  localparam int         MATCH_BASE  = 2;
  localparam logic [5:0] IDX_STATUS  = 6'd8;
  localparam logic [5:0] IDX_IRQ_EN  = 6'd9;
  localparam logic [5:0] IDX_WDT_EN  = 6'd10;
  localparam logic [5:0] IDX_DIV     = 6'd11;
  localparam logic [5:0] IDX_LATCH   = 6'd12;
  localparam logic [5:0] IDX_SNAP_LO = 6'd13;
  localparam logic [5:0] IDX_SNAP_HI = 6'd14;

  // Next counter value after one advance (carry ripples into the high half)
  function automatic logic [63:0] cnt_step(input logic [63:0] c);
    return c + 64'd1;
  endfunction

  // Low-half value that the next advance will produce
  function automatic logic [31:0] lo_next(input logic [63:0] c);
    return c[31:0] + 32'd1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  // period is 2*(div+1) clocks: last phase index is 2*div+1
  assign limit  = {div_i, 1'b1};
  assign tick_o = (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + PW'(1);
  end

  // The shortest period is two clocks, so two ticks are never adjacent
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        latch_i,
  output logic        adv_o,
  output logic [63:0] cnt_o,
  output logic [63:0] snap_o
);
  logic [63:0] cnt_q;
  logic [63:0] snap_q;

  // a direct write wins over an advance in the same clock
  assign adv_o = tick_i && !wr_lo_i && !wr_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_q[31:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[63:32] <= wdata_i;
    end else if (adv_o) begin
      cnt_q <= cnt_step(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (latch_i) snap_q <= cnt_q;
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> (cnt_q == $past(cnt_q) + 64'd1)); // R3
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R2
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(snap_q)); // R5
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv_i,
  input  logic [63:0]            cnt_i,
  input  logic [NUM_CH-1:0]      we_i,
  input  logic [31:0]            wdata_i,
  input  logic [NUM_CH-1:0]      clr_i,
  output logic [NUM_CH-1:0][31:0] match_o,
  output logic [NUM_CH-1:0]      hit_o,
  output logic [NUM_CH-1:0]      status_o
);
  logic [NUM_CH-1:0] st_q;
  logic [31:0]       lo_nx;

  assign lo_nx = lo_next(cnt_i);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [31:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (we_i[i]) cmp_q <= wdata_i;
    end

    assign match_o[i] = cmp_q;
    assign hit_o[i]   = adv_i && (lo_nx == cmp_q);

    // new hit has priority over a clear in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q[i] <= 1'b0;
      else if (hit_o[i]) st_q[i] <= 1'b1;
      else if (clr_i[i]) st_q[i] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr_i[i]) |=> st_q[i]); // R7
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[i]) |-> $past(adv_i)); // R6
  end

  assign status_o = st_q;
endmodule

// File: rtl/snap_match_timer.sv
module snap_match_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WDT_CH = 5,
  parameter int DIV_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        wdt_rst_req_o
);
  localparam int ST_PAD  = 32 - NUM_CH;
  localparam int DIV_PAD = 32 - DIV_W;

  logic [5:0]  idx;
  logic        wr_ok;
  logic        tick;
  logic        adv;
  logic [63:0] cnt;
  logic [63:0] snap;

  logic [NUM_CH-1:0]       match_we;
  logic [NUM_CH-1:0][31:0] match_q;
  logic [NUM_CH-1:0]       hit;
  logic [NUM_CH-1:0]       status;
  logic [NUM_CH-1:0]       st_clr;
  logic [NUM_CH-1:0]       irq_en_q;
  logic                    wdt_en_q;
  logic [DIV_W-1:0]        div_q;
  logic                    wdt_req_q;
  logic                    latch_cmd;

  assign idx   = bus_addr[7:2];
  assign wr_ok = bus_wr && (bus_addr[1:0] == 2'b00);

  assign latch_cmd = wr_ok && (idx == IDX_LATCH) && bus_wdata[0];
  assign st_clr    = (wr_ok && idx == IDX_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_we
    assign match_we[i] = wr_ok && (idx == 6'(MATCH_BASE + i));
  end

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (div_q),
    .tick_o (tick)
  );

  tmr_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .wr_lo_i (wr_ok && idx == IDX_CNT_LO),
    .wr_hi_i (wr_ok && idx == IDX_CNT_HI),
    .wdata_i (bus_wdata),
    .latch_i (latch_cmd),
    .adv_o   (adv),
    .cnt_o   (cnt),
    .snap_o  (snap)
  );

  tmr_match_bank #(.NUM_CH(NUM_CH)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .cnt_i    (cnt),
    .we_i     (match_we),
    .wdata_i  (bus_wdata),
    .clr_i    (st_clr),
    .match_o  (match_q),
    .hit_o    (hit),
    .status_o (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      wdt_en_q <= 1'b0;
      div_q    <= '0;
    end else if (wr_ok) begin
      if (idx == IDX_IRQ_EN) irq_en_q <= bus_wdata[NUM_CH-1:0];
      if (idx == IDX_WDT_EN) wdt_en_q <= bus_wdata[0];
      if (idx == IDX_DIV)    div_q    <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wdt_req_q <= 1'b0;
    else if (hit[WDT_CH] && wdt_en_q)    wdt_req_q <= 1'b1;
  end

  assign irq_o         = |(status & irq_en_q);
  assign wdt_rst_req_o = wdt_req_q;

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_CNT_LO:  bus_rdata = cnt[31:0];
      IDX_CNT_HI:  bus_rdata = cnt[63:32];
      IDX_STATUS:  bus_rdata = {{ST_PAD{1'b0}}, status};
      IDX_IRQ_EN:  bus_rdata = {{ST_PAD{1'b0}}, irq_en_q};
      IDX_WDT_EN:  bus_rdata = {31'd0, wdt_en_q};
      IDX_DIV:     bus_rdata = {{DIV_PAD{1'b0}}, div_q};
      IDX_SNAP_LO: bus_rdata = snap[31:0];
      IDX_SNAP_HI: bus_rdata = snap[63:32];
      default:     bus_rdata = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++)
      if (idx == 6'(MATCH_BASE + i)) bus_rdata = match_q[i];
  end

  AST_WDT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req_o |=> wdt_rst_req_o); // R9
  AST_WDT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_req_o) |-> $past(wdt_en_q)); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq_o); // R8
endmodule

// File: tb/snap_match_timer_tb.sv
module snap_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        wdt_rst_req_o;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_ST = 8'h20, A_EN = 8'h24,
                         A_WDT = 8'h28, A_DIV = 8'h2C, A_LAT = 8'h30,
                         A_SLO = 8'h34, A_SHI = 8'h38;

  always #10 clk = ~clk; // 50 MHz

  snap_match_timer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq_o         (irq_o),
    .wdt_rst_req_o (wdt_rst_req_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge, returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] a_match(input int ch);
    return 8'(8 + 4 * ch);
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, s1, s2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_LO, v);  check("R1 cnt lo", v, 0);
    rd(A_HI, v);  check("R1 cnt hi", v, 0);
    rd(A_ST, v);  check("R1 status", v, 0);
    rd(A_EN, v);  check("R1 irq en", v, 0);
    rd(A_WDT, v); check("R1 wdt en", v, 0);
    rd(A_DIV, v); check("R1 div", v, 0);
    rd(A_SLO, v); check("R1 snap lo", v, 0);
    rd(A_SHI, v); check("R1 snap hi", v, 0);
    check("R1 irq", irq_o, 0);
    check("R1 wdt req", wdt_rst_req_o, 0);

    // R10: readback
    for (int ch = 0; ch < 6; ch++) wr(a_match(ch), 32'hA500_0000 | ch);
    for (int ch = 0; ch < 6; ch++) begin
      rd(a_match(ch), v); check("R10 match readback", v, 32'hA500_0000 | ch);
    end
    wr(A_DIV, 32'h0000_1234); rd(A_DIV, v); check("R10 div readback", v, 32'h1234);
    wr(A_EN, 32'h2A);         rd(A_EN, v);  check("R10 en readback", v, 32'h2A);
    wr(A_EN, 32'h0);
    wr(A_WDT, 32'h1);         rd(A_WDT, v); check("R10 wdt readback", v, 1);
    wr(A_WDT, 32'h0);

    // R2: prescale sweep, exact advance over whole periods
    for (int d = 0; d < 6; d++) begin
      int m;
      m = 2 * (d + 1) * 7;
      wr(A_DIV, d);
      wr(A_LAT, 1); rd(A_SLO, s1);
      repeat (m - 1) @(negedge clk);
      wr(A_LAT, 1); rd(A_SLO, s2);
      check($sformatf("R2 advance div=%0d", d), s2 - s1, 7);
    end

    // R4: write beats advance, both tick phases at div=0
    wr(A_DIV, 0);
    for (int ph = 0; ph < 2; ph++) begin
      repeat (ph) @(negedge clk);
      wr(A_LO, 32'd100);
      wr(A_LAT, 1);
      rd(A_SLO, v); check($sformatf("R4 lo write phase %0d", ph), v, 100);
      wr(A_HI, 32'h77);
      wr(A_LAT, 1);
      rd(A_SHI, v); check($sformatf("R4 hi write phase %0d", ph), v, 32'h77);
    end

    // R5: capture hold, bit0 clear ignored, command reads zero
    wr(A_LAT, 1); rd(A_SLO, s1); rd(A_SHI, s2);
    repeat (20) @(negedge clk);
    rd(A_SLO, v); check("R5 hold lo", v, s1);
    wr(A_LAT, 32'h2);
    rd(A_SLO, v); check("R5 bit0 clear lo", v, s1);
    rd(A_SHI, v); check("R5 bit0 clear hi", v, s2);
    rd(A_LAT, v); check("R5 command reads zero", v, 0);

    // R3: carry and 64-bit wrap (high half written first)
    wr(A_DIV, 3);
    wr(A_HI, 32'd5); wr(A_LO, 32'hFFFF_FFFE);
    repeat (40) @(negedge clk);
    wr(A_LAT, 1);
    rd(A_SHI, v); check("R3 carry hi", v, 6);
    rd(A_SLO, v); check("R3 carry lo small", (v < 16), 1);
    wr(A_HI, 32'hFFFF_FFFF); wr(A_LO, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    wr(A_LAT, 1);
    rd(A_SHI, v); check("R3 wrap hi", v, 0);
    rd(A_SLO, v); check("R3 wrap lo small", (v < 16), 1);

    // R6/R7/R8: each channel alone, div=0
    wr(A_DIV, 0);
    for (int ch = 0; ch < 6; ch++) begin
      for (int k = 0; k < 6; k++) wr(a_match(k), 32'hFFFF_0000);
      wr(A_HI, 0); wr(A_LO, 0);
      wr(a_match(ch), 32'd30);
      wr(A_ST, 32'h3F);
      repeat (80) @(negedge clk);
      rd(A_ST, v); check($sformatf("R6 status ch%0d", ch), v, 32'(1 << ch));
      check("R8 flag without enable", irq_o, 0);
      wr(A_EN, 32'(1 << ch)); check($sformatf("R8 irq ch%0d", ch), irq_o, 1);
      wr(A_EN, 32'h3F & ~32'(1 << ch)); check("R8 other enables", irq_o, 0);
      wr(A_EN, 32'(1 << ch));
      wr(A_ST, 32'h3F & ~32'(1 << ch));
      rd(A_ST, v); check("R7 zero bits keep flag", v, 32'(1 << ch));
      wr(A_ST, 32'(1 << ch));
      rd(A_ST, v); check("R7 clear", v, 0);
      check("R7 irq after clear", irq_o, 0);
      wr(A_EN, 0);
    end
    check("R9 disarmed hit", wdt_rst_req_o, 0);

    // R6: exact count when the flag appears (div=1)
    wr(A_DIV, 1);
    wr(a_match(0), 32'd100);
    wr(A_HI, 0); wr(A_LO, 0);
    wr(A_ST, 32'h3F);
    for (int t = 0; t < 1000; t++) begin
      rd(A_ST, v);
      if (v[0]) break;
      @(negedge clk);
    end
    wr(A_LAT, 1);
    rd(A_SLO, v); check("R6 exact match count", v, 100);

    // R9: armed watchdog
    wr(A_DIV, 0);
    wr(A_WDT, 1);
    wr(A_HI, 0); wr(A_LO, 0);
    wr(a_match(5), 32'd30);
    wr(A_ST, 32'h3F);
    repeat (80) @(negedge clk);
    check("R9 armed hit", wdt_rst_req_o, 1);
    wr(A_WDT, 0); wr(A_ST, 32'h3F);
    repeat (10) @(negedge clk);
    check("R9 sticky", wdt_rst_req_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule